// File: doc/BRIEF.md
# Paged Register Access Bridge

This block lets a host processor reach a paged register space inside a switch through six host-visible registers. The host first claims ownership by setting a request bit in a control register and waiting for a grant bit. Once it owns the bridge, the host stages up to 64 bits of write data, then writes a command word. That word names an 8-bit page and an 8-bit register offset, says whether the access is a read or a write, and carries a go bit that starts the transfer. The go bit then reads back as a busy flag until the internal side acknowledges. A read's 64-bit result lands in two read-data words. Both words are loaded in the same cycle, so they always come from one transfer.

The host bus is a plain 32-bit, word-addressed, single-cycle bus. Writes take effect on the clock edge that samples `hb_wr`. Read data appears on `hb_rdata` the cycle after `hb_rd` is sampled. The word addresses are 0x0B (command/status), 0x0C (write data high), 0x0D (write data low), 0x0E (read data high), 0x0F (read data low) and 0x10 (control/status). They are byte offsets 0x2C to 0x40 divided by four, and any other address reads zero.

The internal request is a valid/ready channel. `xfer_valid` rises the cycle after an accepted go. The request fields are held stable until a cycle with `xfer_valid` and `xfer_ready` both high. Only the reset bit may withdraw the request early. The response is a single-cycle `rsp_valid` pulse with no back-pressure. It is counted only after the request has been accepted, and it must come at least one cycle after the handshake. Narrow accesses (8, 16 or 32 bits) use only the low write word. A 48-bit read uses the low word plus the low 16 bits of the high word; software does the masking.

Top module: `srab_bridge`

## Requirements
- R1: After reset, every host register reads zero except control bit 6, which follows `sw_init_done`. `host_grant`, `xfer_valid` and `host_irq_en` are 0.
- R2: `host_grant` rises GRANT_DELAY cycles after the request bit (control bit 3) first reads 1. Each cycle in which `owner_busy` is 1 while the grant is still pending stretches this by one cycle.
- R3: `host_grant` falls exactly one cycle after the write that clears the request bit.
- R4: The command word holds the page in bits 31:24, the register offset in bits 23:16, write-when-set in bit 1 and go/busy in bit 0. Bit 2 is the reset request and reads 0, as do bits 15:3. A write with grant held, not busy and bit 0 clear stores the fields without starting a transfer.
- R5: A command write with bit 0 set, grant held and busy clear raises `xfer_valid` one cycle later. The request then carries the written page, register offset and write flag, with `xfer_wdata` = {write-data high, write-data low}.
- R6: Bit 0 of the command word reads 1 from the cycle after the go is accepted until the `rsp_valid` cycle. It reads 0 from the cycle after that.
- R7: On the response to a read, both read-data words load from `rsp_data` (high word = bits 63:32) in the same cycle. A response to a write leaves them unchanged.
- R8: A command write is ignored, and page, offset and write flag keep their values, when the grant is not held or busy is 1 (unless bit 2 is set). Write-data writes are ignored while busy.
- R9: A command write with bit 2 set clears both write-data words, both read-data words, the command fields and busy, and drops `xfer_valid`. This happens whatever the grant or busy state.
- R10: In the control register, bit 1 is a read/write interrupt enable driven on `host_irq_en`, and bit 3 is the read/write request. Bit 4 reads the grant and bit 6 reads `sw_init_done`; writes to both are ignored. All other bits read 0.
- R11: While `xfer_valid` is 1 and `xfer_ready` is 0, `xfer_valid` and all request fields hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hb_addr | input | ADDR_W | Host word address |
| hb_wr | input | 1 | Host write strobe |
| hb_rd | input | 1 | Host read strobe |
| hb_wdata | input | 32 | Host write data |
| hb_rdata | output | 32 | Host read data, valid the cycle after `hb_rd` |
| owner_busy | input | 1 | Internal owner is using the switch registers |
| sw_init_done | input | 1 | Switch initialization finished |
| host_grant | output | 1 | Host owns the bridge |
| host_irq_en | output | 1 | Host interrupt enable bit |
| xfer_valid | output | 1 | Internal request valid |
| xfer_ready | input | 1 | Internal request accepted |
| xfer_page | output | 8 | Request page |
| xfer_reg | output | 8 | Request register offset |
| xfer_write | output | 1 | Request is a write |
| xfer_wdata | output | 64 | Request write data |
| rsp_valid | input | 1 | Internal response pulse |
| rsp_data | input | 64 | Internal read data |

## Verification
The bench drives inputs and samples outputs on the falling edge, and counts every result from the rising edge that takes the stimulus.
- **Grant timing:** the grant is measured in cycles after the request write, with and without an owner stall. It is checked still high at the first falling edge after the release write and low at the next.
- **Host reads:** every register value is checked one cycle after its read strobe.
- **Transfers:** busy is read immediately after a go, then polled until it clears. The read-data words are checked only after busy has dropped.
- **Responder:** a model of the internal side varies how long it waits before asserting ready, and how long after acceptance it responds.

// File: rtl/srab_pkg.sv
package srab_pkg;
  localparam int HOST_W  = 32;
  localparam int PAGE_W  = 8;
  localparam int REGO_W  = 8;
  localparam int XDATA_W = 2 * HOST_W;

  localparam int WA_CMD = 'h0B;
  localparam int WA_WDH = 'h0C;
  localparam int WA_WDL = 'h0D;
  localparam int WA_RDH = 'h0E;
  localparam int WA_RDL = 'h0F;
  localparam int WA_CTL = 'h10;

  localparam int CB_GO   = 0;
  localparam int CB_WR   = 1;
  localparam int CB_RST  = 2;
  localparam int CB_REGO = 16;
  localparam int CB_PAGE = 24;

  localparam int KB_IE   = 1;
  localparam int KB_REQ  = 3;
  localparam int KB_GNT  = 4;
  localparam int KB_INIT = 6;

  typedef enum logic [1:0] {
    XS_IDLE  = 2'd0,
    XS_ISSUE = 2'd1,
    XS_WAIT  = 2'd2
  } xfer_state_t;
endpackage

// File: rtl/srab_arbiter.sv
module srab_arbiter #(
  parameter int GRANT_DELAY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic owner_busy_i,
  output logic grant_o
);
  localparam int CNT_W = $clog2(GRANT_DELAY + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(GRANT_DELAY - 1);

  logic [CNT_W-1:0] wait_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_o  <= 1'b0;
      wait_cnt <= '0;
    end else if (!req_i) begin
      grant_o  <= 1'b0;
      wait_cnt <= '0;
    end else if (!grant_o && !owner_busy_i) begin
      if (wait_cnt == LAST) grant_o <= 1'b1;
      else wait_cnt <= wait_cnt + 1'b1;
    end
  end

  // R3: a cleared request removes the grant on the next edge
  a_r3_drop_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> !grant_o);
  // R2: the grant never rises without a standing request
  a_r2_rise_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_o) |-> $past(req_i));
  // R2: no grant is taken while the owner is busy
  a_r2_owner_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_o && owner_busy_i) |=> !grant_o);
endmodule

// File: rtl/srab_xfer.sv
module srab_xfer
  import srab_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic launch_i,
  input  logic abort_i,
  input  logic wr_i,
  input  logic ready_i,
  input  logic rsp_valid_i,
  output logic valid_o,
  output logic busy_o,
  output logic rd_load_o
);
  xfer_state_t state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= XS_IDLE;
    else if (abort_i) state <= XS_IDLE;
    else begin
      case (state)
        XS_IDLE:  if (launch_i) state <= XS_ISSUE;
        XS_ISSUE: if (ready_i) state <= XS_WAIT;
        XS_WAIT:  if (rsp_valid_i) state <= XS_IDLE;
        default:  state <= XS_IDLE;
      endcase
    end
  end

  assign valid_o   = (state == XS_ISSUE);
  assign busy_o    = (state != XS_IDLE);
  assign rd_load_o = (state == XS_WAIT) && rsp_valid_i && !wr_i && !abort_i;

  // R11: an offered request stays offered until taken
  a_r11_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i && !abort_i) |=> valid_o);
  // R6: the response ends the busy period
  a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == XS_WAIT) && rsp_valid_i) |=> !busy_o);
  // R5: an accepted go offers the request on the next cycle
  a_r5_launch_offers: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_i && !busy_o && !abort_i) |=> valid_o);
endmodule

// File: rtl/srab_bridge.sv
module srab_bridge
  import srab_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int GRANT_DELAY = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   hb_addr,
  input  logic                hb_wr,
  input  logic                hb_rd,
  input  logic [HOST_W-1:0]   hb_wdata,
  output logic [HOST_W-1:0]   hb_rdata,
  input  logic                owner_busy,
  input  logic                sw_init_done,
  output logic                host_grant,
  output logic                host_irq_en,
  output logic                xfer_valid,
  input  logic                xfer_ready,
  output logic [PAGE_W-1:0]   xfer_page,
  output logic [REGO_W-1:0]   xfer_reg,
  output logic                xfer_write,
  output logic [XDATA_W-1:0]  xfer_wdata,
  input  logic                rsp_valid,
  input  logic [XDATA_W-1:0]  rsp_data
);
  logic [PAGE_W-1:0] cmd_page;
  logic [REGO_W-1:0] cmd_rego;
  logic              cmd_wr;
  logic [HOST_W-1:0] wd_hi, wd_lo, rd_hi, rd_lo;
  logic              ctl_req, ctl_ie;
  logic              busy, rd_load;
  logic [HOST_W-1:0] rmux;

  logic sel_cmd, sel_wdh, sel_wdl, sel_ctl;
  assign sel_cmd = hb_wr && (hb_addr == ADDR_W'(WA_CMD));
  assign sel_wdh = hb_wr && (hb_addr == ADDR_W'(WA_WDH));
  assign sel_wdl = hb_wr && (hb_addr == ADDR_W'(WA_WDL));
  assign sel_ctl = hb_wr && (hb_addr == ADDR_W'(WA_CTL));

  logic rst_hit, cmd_take, launch;
  assign rst_hit  = sel_cmd && hb_wdata[CB_RST];
  assign cmd_take = sel_cmd && !hb_wdata[CB_RST] && host_grant && !busy;
  assign launch   = cmd_take && hb_wdata[CB_GO];

  logic unused_wbits;
  assign unused_wbits = ^hb_wdata[CB_REGO-1:CB_RST+1];

  srab_arbiter #(.GRANT_DELAY(GRANT_DELAY)) u_arb (
    .clk(clk), .rst_n(rst_n), .req_i(ctl_req),
    .owner_busy_i(owner_busy), .grant_o(host_grant)
  );

  srab_xfer u_xfer (
    .clk(clk), .rst_n(rst_n), .launch_i(launch), .abort_i(rst_hit),
    .wr_i(cmd_wr), .ready_i(xfer_ready), .rsp_valid_i(rsp_valid),
    .valid_o(xfer_valid), .busy_o(busy), .rd_load_o(rd_load)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_page <= '0; cmd_rego <= '0; cmd_wr <= 1'b0;
    end else if (rst_hit) begin
      cmd_page <= '0; cmd_rego <= '0; cmd_wr <= 1'b0;
    end else if (cmd_take) begin
      cmd_page <= hb_wdata[CB_PAGE +: PAGE_W];
      cmd_rego <= hb_wdata[CB_REGO +: REGO_W];
      cmd_wr   <= hb_wdata[CB_WR];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_hi <= '0; wd_lo <= '0;
    end else if (rst_hit) begin
      wd_hi <= '0; wd_lo <= '0;
    end else if (!busy) begin
      if (sel_wdh) wd_hi <= hb_wdata;
      if (sel_wdl) wd_lo <= hb_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_hi <= '0; rd_lo <= '0;
    end else if (rst_hit) begin
      rd_hi <= '0; rd_lo <= '0;
    end else if (rd_load) begin
      rd_hi <= rsp_data[XDATA_W-1:HOST_W];
      rd_lo <= rsp_data[HOST_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_req <= 1'b0; ctl_ie <= 1'b0;
    end else if (sel_ctl) begin
      ctl_req <= hb_wdata[KB_REQ];
      ctl_ie  <= hb_wdata[KB_IE];
    end
  end

  always_comb begin
    rmux = '0;
    case (hb_addr)
      ADDR_W'(WA_CMD): begin
        rmux[CB_PAGE +: PAGE_W] = cmd_page;
        rmux[CB_REGO +: REGO_W] = cmd_rego;
        rmux[CB_WR]             = cmd_wr;
        rmux[CB_GO]             = busy;
      end
      ADDR_W'(WA_WDH): rmux = wd_hi;
      ADDR_W'(WA_WDL): rmux = wd_lo;
      ADDR_W'(WA_RDH): rmux = rd_hi;
      ADDR_W'(WA_RDL): rmux = rd_lo;
      ADDR_W'(WA_CTL): begin
        rmux[KB_IE]   = ctl_ie;
        rmux[KB_REQ]  = ctl_req;
        rmux[KB_GNT]  = host_grant;
        rmux[KB_INIT] = sw_init_done;
      end
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hb_rdata <= '0;
    else if (hb_rd) hb_rdata <= rmux;
  end

  assign host_irq_en = ctl_ie;
  assign xfer_page   = cmd_page;
  assign xfer_reg    = cmd_rego;
  assign xfer_write  = cmd_wr;
  assign xfer_wdata  = {wd_hi, wd_lo};

  // R8: a refused command leaves the fields alone
  a_r8_cmd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_cmd && !hb_wdata[CB_RST] && (!host_grant || busy))
      |=> ($stable(cmd_page) && $stable(cmd_rego) && $stable(cmd_wr)));
  // R7: read data changes only on a read response or a reset write
  a_r7_atomic_load: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({rd_hi, rd_lo}) |-> $past(rd_load || rst_hit));
  // R9: the reset bit clears busy, the request and the read data
  a_r9_reset_bit: assert property (@(posedge clk) disable iff (!rst_n)
    rst_hit |=> (!busy && !xfer_valid && rd_hi == '0 && rd_lo == '0));
  // R11: request fields hold while waiting for ready
  a_r11_fields_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_ready && !rst_hit)
      |=> ($stable(xfer_page) && $stable(xfer_reg) && $stable(xfer_wdata)));
endmodule

// File: tb/srab_bridge_tb.sv
module srab_bridge_tb;
  localparam int GD = 4;
  localparam logic [5:0] A_CMD = 6'h0B, A_WDH = 6'h0C, A_WDL = 6'h0D,
                         A_RDH = 6'h0E, A_RDL = 6'h0F, A_CTL = 6'h10;

  logic clk = 0, rst_n = 0;
  logic [5:0] hb_addr = '0;
  logic hb_wr = 0, hb_rd = 0;
  logic [31:0] hb_wdata = '0, hb_rdata;
  logic owner_busy = 0, sw_init_done = 1;
  logic host_grant, host_irq_en, xfer_valid, xfer_write;
  logic xfer_ready = 0, rsp_valid = 0;
  logic [7:0] xfer_page, xfer_reg;
  logic [63:0] xfer_wdata, rsp_data = '0;

  srab_bridge #(.ADDR_W(6), .GRANT_DELAY(GD)) u_dut (
    .clk(clk), .rst_n(rst_n), .hb_addr(hb_addr), .hb_wr(hb_wr), .hb_rd(hb_rd),
    .hb_wdata(hb_wdata), .hb_rdata(hb_rdata), .owner_busy(owner_busy),
    .sw_init_done(sw_init_done), .host_grant(host_grant), .host_irq_en(host_irq_en),
    .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_page(xfer_page),
    .xfer_reg(xfer_reg), .xfer_write(xfer_write), .xfer_wdata(xfer_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  always #4 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // Internal-side model
  logic [63:0] mem [logic [15:0]];
  function automatic logic [63:0] model(input logic [7:0] p, input logic [7:0] r);
    if (mem.exists({p, r})) return mem[{p, r}];
    return {p ^ 8'hC0, r, 16'hBEEF, p, r, 16'h1234};
  endfunction

  int phase = 0, ack_cnt = 0, gap = 0;
  bit hold_ready = 0;
  logic [7:0] rec_page, rec_reg;
  logic rec_wr;
  logic [63:0] rec_wdata;

  always @(negedge clk) begin
    xfer_ready = 0;
    rsp_valid  = 0;
    if (!rst_n) phase = 0;
    else if (phase == 2) begin
      if (ack_cnt == 0) begin
        rsp_valid = 1;
        rsp_data  = rec_wr ? {$urandom, $urandom} : model(rec_page, rec_reg);
        if (rec_wr) mem[{rec_page, rec_reg}] = rec_wdata;
        gap   = $urandom_range(0, 2);
        phase = 0;
      end else ack_cnt--;
    end else if (phase == 1) begin
      ack_cnt = $urandom_range(0, 2);
      phase   = 2;
    end else if (xfer_valid && !hold_ready) begin
      if (gap > 0) gap--;
      else begin
        xfer_ready = 1;
        rec_page = xfer_page; rec_reg = xfer_reg;
        rec_wr = xfer_write; rec_wdata = xfer_wdata;
        phase = 1;
      end
    end
  end

  task automatic hwrite(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); hb_addr = a; hb_wdata = d; hb_wr = 1;
    @(negedge clk); hb_wr = 0;
  endtask

  task automatic hread(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); hb_addr = a; hb_rd = 1;
    @(negedge clk); hb_rd = 0; d = hb_rdata;
  endtask

  task automatic wait_idle(output logic [31:0] c);
    for (int i = 0; i < 50; i++) begin
      hread(A_CMD, c);
      if (!c[0]) break;
    end
  endtask

  initial begin
    logic [31:0] v, hi, lo, c;
    logic [63:0] exp_rd;
    int k;
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    hread(A_CMD, v); chk(v == 0, "R1 cmd", v, 0);
    hread(A_CTL, v); chk(v == 32'h40, "R1 ctl", v, 32'h40);
    hread(A_RDL, v); chk(v == 0, "R1 rdl", v, 0);
    chk(!host_grant && !xfer_valid && !host_irq_en, "R1 outputs",
        {host_grant, xfer_valid, host_irq_en}, 0);

    // R10 control bits
    hwrite(A_CTL, 32'h2);
    hread(A_CTL, v); chk(v == 32'h42, "R10 ie", v, 32'h42);
    chk(host_irq_en == 1, "R10 irq_en pin", host_irq_en, 1);
    hwrite(A_CTL, 32'hFFFF_FFB7);
    hread(A_CTL, v); chk(v == 32'h42, "R10 ro bits", v, 32'h42);
    hwrite(A_CTL, 32'h0);

    // R2 grant delay, owner idle
    hwrite(A_CTL, 32'h8);
    k = 0;
    while (!host_grant && k < 100) begin @(negedge clk); k++; end
    chk(k == GD, "R2 delay idle", k, GD);
    hwrite(A_CTL, 32'h0);
    repeat (2) @(negedge clk);

    // R2 grant delay with owner stall of 3 cycles
    owner_busy = 1;
    hwrite(A_CTL, 32'h8);
    k = 0;
    repeat (3) begin @(negedge clk); k++; end
    owner_busy = 0;
    while (!host_grant && k < 100) begin @(negedge clk); k++; end
    chk(k == GD + 3, "R2 delay stalled", k, GD + 3);

    // R4 field storage without go, undefined bits read zero
    hwrite(A_CMD, 32'hA53C_FFFA);
    hread(A_CMD, v); chk(v == 32'hA53C_0002, "R4 readback", v, 32'hA53C_0002);
    chk(!xfer_valid, "R4 no start", xfer_valid, 0);

    // Random transfers: R5 R6 R7
    exp_rd = 0;
    for (int t = 0; t < 40; t++) begin
      logic [7:0] p, r;
      logic w;
      p = 8'($urandom_range(0, 3)); r = 8'($urandom_range(0, 3));
      w = 1'($urandom_range(0, 1));
      hi = $urandom; lo = $urandom;
      hwrite(A_WDH, hi); hwrite(A_WDL, lo);
      if (!w) exp_rd = model(p, r);
      hwrite(A_CMD, {p, r, 14'd0, w, 1'b1});
      hread(A_CMD, v);
      chk(v[0] == 1, "R6 busy after go", v, {p, r, 14'd0, w, 1'b1});
      wait_idle(c);
      chk(c == {p, r, 14'd0, w, 1'b0}, "R6 idle readback", c, {p, r, 14'd0, w, 1'b0});
      chk(rec_page == p && rec_reg == r && rec_wr == w, "R5 request fields",
          {rec_page, rec_reg, 7'd0, rec_wr}, {p, r, 7'd0, w});
      if (w) chk(rec_wdata == {hi, lo}, "R5 write data", rec_wdata, {hi, lo});
      hread(A_RDH, hi); hread(A_RDL, lo);
      chk({hi, lo} == exp_rd, "R7 read data", {hi, lo}, exp_rd);
    end

    // R8 busy ignores commands and write data; R11 hold
    hwrite(A_WDL, 32'h1111);
    hold_ready = 1;
    hwrite(A_CMD, 32'h1122_0001);
    hwrite(A_CMD, 32'h3344_0003);
    hwrite(A_WDL, 32'hDEAD);
    repeat (4) @(negedge clk);
    hread(A_CMD, v); chk(v == 32'h1122_0001, "R8 busy ignore", v, 32'h1122_0001);
    hread(A_WDL, v); chk(v == 32'h1111, "R8 wdata ignore", v, 32'h1111);
    chk(xfer_valid && xfer_page == 8'h11 && xfer_reg == 8'h22, "R11 held request",
        {xfer_valid, xfer_page, xfer_reg}, {1'b1, 8'h11, 8'h22});

    // R9 reset bit
    hwrite(A_CMD, 32'h4);
    chk(!xfer_valid, "R9 valid dropped", xfer_valid, 0);
    hread(A_CMD, v); chk(v == 0, "R9 cmd cleared", v, 0);
    hread(A_WDL, v); chk(v == 0, "R9 wdl cleared", v, 0);
    hread(A_WDH, v); chk(v == 0, "R9 wdh cleared", v, 0);
    hread(A_RDL, lo); hread(A_RDH, hi);
    chk({hi, lo} == 0, "R9 rd cleared", {hi, lo}, 0);
    hold_ready = 0;

    // R3 grant drop
    hwrite(A_CTL, 32'h0);
    chk(host_grant == 1, "R3 grant one more cycle", host_grant, 1);
    @(negedge clk);
    chk(host_grant == 0, "R3 grant dropped", host_grant, 0);

    // R8 command without grant
    hwrite(A_CMD, 32'h7766_0001);
    repeat (3) @(negedge clk);
    chk(!xfer_valid, "R8 no grant no start", xfer_valid, 0);
    hread(A_CMD, v); chk(v == 0, "R8 no grant fields", v, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule